// File: doc/BRIEF.md
# Byte-Lane Delay Trend Checker

After read leveling, every byte lane has its own read delay. On a memory channel routed as a fly-by chain these delays should change steadily from one end of the chain to the other. This block takes the delays one lane per clock, starting at lane 0 and ending at the last lane. For each pair of neighbouring lanes it checks two rules: the delays must keep to one direction, and the step between neighbours must not be too large. After the sweep it gives one verdict.

The first pair of neighbours whose delays differ sets the direction, rising or falling. Neighbours with equal delays are allowed under either direction. An input bit turns off the direction rule. A step-limit input sets the largest allowed absolute difference between neighbours, and a limit of zero turns off the step rule. The verdict has a reason code and the index of the first lane that broke a rule. It stays on the outputs until the next sweep starts. Whatever feeds the delays uses the verdict to accept the leveling result or to reject it.

Top module: `lane_trend_checker`

## Requirements
- R1: After reset, `done` is 0, `reason` is 0 and `bad_lane` is 0.
- R2: A sweep whose delays never fall between neighbours ends with `reason` = 0 (pass). Equal neighbours are allowed.
- R3: A sweep whose delays never rise between neighbours also ends with `reason` = 0.
- R4: The first pair of unequal neighbours sets the direction. A later lane that moves the other way sets `reason` = 1 (trend fault). `bad_lane` is then the higher-numbered lane of the pair.
- R5: When `trend_off` = 1, a change of direction does not raise a fault.
- R6: A neighbour difference greater than `step_limit` sets `reason` = 2 (step fault). A difference equal to the limit passes.
- R7: When `step_limit` = 0, no step fault is raised, however large the differences are.
- R8: When one lane breaks both rules, `reason` = 1.
- R9: Only the first fault of a sweep is reported. Faults at later lanes change neither `reason` nor `bad_lane`.
- R10: `done` is high for exactly one cycle, the cycle after the last lane (lane 8) is accepted. Cycles with `lane_valid` low do not advance the lane count.
- R11: The verdict holds after `done`. It is cleared only when lane 0 of the next sweep is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | 1 | A lane delay is offered this cycle |
| lane_delay | input | 6 | Delay of the current lane, unsigned |
| trend_off | input | 1 | 1 disables the direction rule |
| step_limit | input | 4 | Largest allowed neighbour difference; 0 disables the step rule |
| done | output | 1 | One-cycle pulse: the verdict for the sweep is final |
| reason | output | 2 | 0 pass, 1 trend fault, 2 step fault |
| bad_lane | output | 4 | Higher lane index of the first failing pair |

## Verification
The hardest cases to reach are a direction that is set late, after a run of equal lanes, and a single lane that breaks both rules at once. The first shows whether equal neighbours leave the direction unset. The second shows which rule wins. The directed sweeps build both cases from chosen delay lists: three equal leading lanes and then a reversal, and a large drop after a rising run with a small limit. A further sweep inserts idle cycles between lanes and puts its fault on the last lane, to show that the lane count and the `done` timing do not depend on gaps.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } dir_e;

   localparam logic [1:0] RSN_PASS  = 2'd0;
   localparam logic [1:0] RSN_TREND = 2'd1;
   localparam logic [1:0] RSN_STEP  = 2'd2;
endpackage

// File: rtl/ltc_lane_seq.sv
module ltc_lane_seq #(
   parameter int LANES  = 9,
   parameter int LANE_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lane_valid,
   output logic [LANE_W-1:0] idx,
   output logic              first_acc,
   output logic              last_acc,
   output logic              done
);
   localparam logic [LANE_W-1:0] LAST_IDX = LANE_W'(LANES - 1);

   assign first_acc = lane_valid && (idx == '0);
   assign last_acc  = lane_valid && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= last_acc;
         if (lane_valid) begin
            idx <= last_acc ? '0 : idx + 1'b1;
         end
      end
   end

   // R10
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(last_acc));
   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);
endmodule

// File: rtl/ltc_pair_eval.sv
module ltc_pair_eval
   import ltc_pkg::*;
#(
   parameter int DELAY_W    = 6,
   parameter int LIMIT_W    = 4,
   parameter bit STEP_CHECK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               first,
   input  logic [DELAY_W-1:0] cur,
   input  logic               trend_off,
   input  logic [LIMIT_W-1:0] limit,
   output logic               trend_bad,
   output logic               step_bad
);
   logic [DELAY_W-1:0] prev;
   dir_e               dir;
   logic               rising;
   logic               falling;
   logic [DELAY_W-1:0] diff;
   logic               pair_ok;

   assign rising  = cur > prev;
   assign falling = cur < prev;
   assign diff    = rising ? (cur - prev) : (prev - cur);
   assign pair_ok = accept && !first;

   assign trend_bad = pair_ok && !trend_off &&
                      (((dir == DIR_UP) && falling) || ((dir == DIR_DOWN) && rising));

   generate
      if (STEP_CHECK) begin : g_step
         assign step_bad = pair_ok && (limit != '0) && (diff > DELAY_W'(limit));
      end else begin : g_no_step
         assign step_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= '0;
         dir  <= DIR_NONE;
      end else if (accept) begin
         prev <= cur;
         if (first) begin
            dir <= DIR_NONE;
         end else if (dir == DIR_NONE) begin
            dir <= rising ? DIR_UP : (falling ? DIR_DOWN : DIR_NONE);
         end
      end
   end

   // R4
   dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir != DIR_NONE) && !(accept && first)) |=> (dir == $past(dir)));
   // R4
   dir_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir != 2'd3);
endmodule

// File: rtl/ltc_first_fault.sv
module ltc_first_fault
   import ltc_pkg::*;
#(
   parameter int LANE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              first,
   input  logic [LANE_W-1:0] idx,
   input  logic              trend_bad,
   input  logic              step_bad,
   output logic [1:0]        reason,
   output logic [LANE_W-1:0] bad_lane
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reason   <= RSN_PASS;
         bad_lane <= '0;
      end else if (accept) begin
         if (first) begin
            reason   <= RSN_PASS;
            bad_lane <= '0;
         end else if ((reason == RSN_PASS) && (trend_bad || step_bad)) begin
            reason   <= trend_bad ? RSN_TREND : RSN_STEP;
            bad_lane <= idx;
         end
      end
   end

   // R9
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((reason != RSN_PASS) && !(accept && first)) |=> ($stable(reason) && $stable(bad_lane)));
   // R4
   bad_lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reason != RSN_PASS) |-> (bad_lane != '0));
   // R8
   reason_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reason != 2'd3);
endmodule

// File: rtl/lane_trend_checker.sv
module lane_trend_checker #(
   parameter int LANES      = 9,
   parameter int DELAY_W    = 6,
   parameter int LIMIT_W    = 4,
   parameter bit STEP_CHECK = 1'b1,
   localparam int LANE_W    = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lane_valid,
   input  logic [DELAY_W-1:0] lane_delay,
   input  logic               trend_off,
   input  logic [LIMIT_W-1:0] step_limit,
   output logic               done,
   output logic [1:0]         reason,
   output logic [LANE_W-1:0]  bad_lane
);
   generate
      if (LANES < 2) begin : g_lanes_bad
         $error("lane_trend_checker: LANES must be at least 2");
      end
      if (LIMIT_W > DELAY_W) begin : g_limit_bad
         $error("lane_trend_checker: LIMIT_W must not exceed DELAY_W");
      end
   endgenerate

   logic [LANE_W-1:0] idx;
   logic              first_acc;
   logic              last_acc;
   logic              trend_bad;
   logic              step_bad;

   ltc_lane_seq #(.LANES(LANES), .LANE_W(LANE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid),
      .idx(idx), .first_acc(first_acc), .last_acc(last_acc), .done(done)
   );

   ltc_pair_eval #(.DELAY_W(DELAY_W), .LIMIT_W(LIMIT_W), .STEP_CHECK(STEP_CHECK)) u_pair (
      .clk(clk), .rst_n(rst_n), .accept(lane_valid), .first(first_acc),
      .cur(lane_delay), .trend_off(trend_off), .limit(step_limit),
      .trend_bad(trend_bad), .step_bad(step_bad)
   );

   ltc_first_fault #(.LANE_W(LANE_W)) u_fault (
      .clk(clk), .rst_n(rst_n), .accept(lane_valid), .first(first_acc),
      .idx(idx), .trend_bad(trend_bad), .step_bad(step_bad),
      .reason(reason), .bad_lane(bad_lane)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!done && (reason == 2'd0) && (bad_lane == '0)));
endmodule

// File: tb/sim_lane_trend_checker.sv
`timescale 1ns/1ps
module sim_lane_trend_checker;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lane_valid = 1'b0;
   logic [5:0] lane_delay = '0;
   logic       trend_off = 1'b0;
   logic [3:0] step_limit = '0;
   logic       done;
   logic [1:0] reason;
   logic [3:0] bad_lane;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [5:0] lanes [9];

   always #2.5 clk = ~clk;

   lane_trend_checker u0 (
      .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_delay(lane_delay),
      .trend_off(trend_off), .step_limit(step_limit),
      .done(done), .reason(reason), .bad_lane(bad_lane)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_sweep(input string req, input bit toff, input logic [3:0] lim,
                            input int gap, input int exp_r, input int exp_l);
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (i == 8) check("R10", "done before last lane", int'(done), 0);
         lane_valid = 1'b1;
         lane_delay = lanes[i];
         trend_off  = toff;
         step_limit = lim;
         if (gap > 0 && i < 8) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               lane_valid = 1'b0;
               lane_delay = 6'h3f;
            end
         end
      end
      @(negedge clk);
      lane_valid = 1'b0;
      check("R10", "done after last lane", int'(done), 1);
      check(req, "reason", int'(reason), exp_r);
      check(req, "bad_lane", int'(bad_lane), exp_l);
      @(negedge clk);
      check("R10", "done one cycle", int'(done), 0);
      check("R11", "reason held", int'(reason), exp_r);
      check("R11", "bad_lane held", int'(bad_lane), exp_l);
   endtask

   // R2 rising with equal neighbours, step equal to limit (R6 boundary)
   task automatic t_rising();
      lanes = '{6'd3, 6'd3, 6'd5, 6'd6, 6'd6, 6'd10, 6'd11, 6'd11, 6'd12};
      run_sweep("R2", 1'b0, 4'd4, 0, 0, 0);
   endtask

   // R3, R7 falling with large steps, limit 0
   task automatic t_falling();
      lanes = '{6'd40, 6'd38, 6'd38, 6'd35, 6'd30, 6'd30, 6'd28, 6'd20, 6'd19};
      run_sweep("R3_R7", 1'b0, 4'd0, 0, 0, 0);
   endtask

   // R4, R9 late direction, reversal at lane 5, later faults ignored
   task automatic t_reversal();
      lanes = '{6'd10, 6'd10, 6'd10, 6'd12, 6'd13, 6'd11, 6'd14, 6'd9, 6'd8};
      run_sweep("R4_R9", 1'b0, 4'd0, 0, 1, 5);
   endtask

   // R5 same pattern with trend rule off
   task automatic t_trend_off();
      lanes = '{6'd10, 6'd10, 6'd10, 6'd12, 6'd13, 6'd11, 6'd14, 6'd9, 6'd8};
      run_sweep("R5", 1'b1, 4'd0, 0, 0, 0);
   endtask

   // R6 step of 6 over limit 3 at lane 4
   task automatic t_step();
      lanes = '{6'd5, 6'd6, 6'd8, 6'd9, 6'd15, 6'd16, 6'd17, 6'd18, 6'd19};
      run_sweep("R6", 1'b0, 4'd3, 0, 2, 4);
   endtask

   // R6 step fault at lane 1 on a falling sweep
   task automatic t_step_first();
      lanes = '{6'd30, 6'd20, 6'd19, 6'd18, 6'd17, 6'd16, 6'd15, 6'd14, 6'd13};
      run_sweep("R6", 1'b0, 4'd4, 0, 2, 1);
   endtask

   // R8 both rules broken at lane 3
   task automatic t_both();
      lanes = '{6'd20, 6'd22, 6'd24, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 6'd15};
      run_sweep("R8", 1'b0, 4'd5, 0, 1, 3);
   endtask

   // R10 idle gaps between lanes, fault on the last lane
   task automatic t_gaps();
      lanes = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd7};
      run_sweep("R10", 1'b0, 4'd0, 2, 1, 8);
   endtask

   // R11 a passing sweep clears a previous fault
   task automatic t_clear();
      lanes = '{6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2};
      run_sweep("R11", 1'b0, 4'd1, 0, 0, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", "done at reset", int'(done), 0);
      check("R1", "reason at reset", int'(reason), 0);
      check("R1", "bad_lane at reset", int'(bad_lane), 0);
      t_rising();
      t_falling();
      t_reversal();
      t_trend_off();
      t_step();
      t_step_first();
      t_both();
      t_gaps();
      t_clear();
      summary();
   end
endmodule